// File: doc/BRIEF.md
# Late-Write Flow-Through Burst SRAM

This block is a cycle-accurate model of a synchronous single-port static memory. Reads are flow-through: the word at a registered read address appears on the output in the cycle that follows the registering edge. Writes are late: the address, direction and byte enables are registered on one enabled edge, and the write data is taken on the next enabled edge. Because both directions have the same one-cycle offset, reads and writes can alternate on every cycle with no idle cycle on the data path.

A load cycle (`adv` low) starts a transfer at a new address. Advance cycles (`adv` high) continue it for up to four beats with a 2-bit counter, following either a wrapping linear order or an interleaved order. A clock-enable input stalls the whole block. Three chip selects qualify each load. The data output is a plain bus paired with a valid flag, in place of a tri-state driver.

Top module: `lwft_sram`

## Requirements
- R1: While `rst_n` is low, and after reset, `rvalid` is low and no write is pending. Write data presented on the first enabled edge after reset changes no memory word.
- R2: On an enabled edge with `adv` = 0 and all chip selects active (`cs0_n` = 0, `cs1` = 1, `cs2_n` = 0), `addr` is registered as the start of a new transfer. `rd_wr_n` = 1 makes it a read and `rd_wr_n` = 0 makes it a write.
- R3: After an enabled edge that registers a read beat, `rdata` holds the stored word at that beat's address in the same cycle, and `rvalid` is high when `out_en` = 1.
- R4: Write data is taken from `wdata` on the enabled edge that follows the edge that registered the write beat. A read registered on that same edge at the same address returns the new data.
- R5: Byte enable `bwe_n[i]` is active low and gates bits `8*i+7 : 8*i`. A write beat with every byte enable high leaves memory unchanged.
- R6: On an enabled edge with `adv` = 1, `addr`, the chip selects and `rd_wr_n` are ignored, and the transfer type chosen at the load continues. `bwe_n` is sampled again for each write beat.
- R7: With `ilv` = 0 at the load, the two low address bits of beat n are (start + n) mod 4, and the upper bits are kept. The address returns to the start after every fourth beat.
- R8: With `ilv` = 1 at the load, the two low address bits of beat n are start XOR n. The order is captured at the load.
- R9: On an edge where `cen_n` = 1, no state changes and no write occurs. A read output stays valid, and a pending write waits for the next enabled edge for its data.
- R10: A load with any chip select inactive is a deselect. Advance beats that follow a deselect stay deselected, with `rvalid` low and no write.
- R11: `rvalid` is high only for read beats while `out_en` = 1. `rdata` is zero whenever `rvalid` is low.
- R12: During write beats `rvalid` is low, whatever the value of `out_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the command pipeline |
| cen_n | input | 1 | Clock enable, active low; high stalls the block |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = advance the burst, 0 = load a new address |
| rd_wr_n | input | 1 | Direction at a load: 1 = read, 0 = write |
| bwe_n | input | NB | Byte write enables, active low, one per lane |
| addr | input | AW | Word address used at a load |
| ilv | input | 1 | Burst order at a load: 1 = interleaved, 0 = linear |
| wdata | input | 8*NB | Write data, taken one enabled edge after its beat |
| out_en | input | 1 | Output enable, combinational qualifier of `rvalid` |
| rdata | output | 8*NB | Flow-through read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The assertions assume that every control input is known at each rising edge while `rst_n` is high, and that `out_en` changes only between edges. Under those assumptions, a stalled read either stays valid or is blanked only by `out_en`. The bench drives every input on the falling edge and never leaves one unknown. It changes `out_en` together with the other inputs, and it compares outputs just before the next falling-edge drive. The memory is filled with known words before any read is checked.

// File: rtl/lwft_pkg.sv
package lwft_pkg;

  typedef enum logic [1:0] {
    OP_DESEL = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low two address bits of a burst beat: XOR for interleaved, modulo-4 sum for linear.
  function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    logic [1:0] r;
    if (ilv) r = start ^ beat;
    else     r = start + beat;
    return r;
  endfunction

  // All three chip selects active.
  function automatic logic chips_on(input logic s0_n, input logic s1, input logic s2_n);
    return (!s0_n) && s1 && (!s2_n);
  endfunction

endpackage

// File: rtl/lwft_burst_addr.sv
module lwft_burst_addr
  import lwft_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic          ilv_in,
  output logic [AW-1:0] beat_addr
);

  localparam int UW = AW - 2;

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic          ilv_q;
  logic          step_evt;
  logic          wrap_evt;

  assign step_evt = en && !load;
  assign wrap_evt = step_evt && (cnt_q == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      ilv_q  <= 1'b0;
    end else if (en) begin
      if (load) begin
        base_q <= start_addr;
        cnt_q  <= 2'd0;
        ilv_q  <= ilv_in;
      end else begin
        cnt_q  <= cnt_q + 2'd1;
      end
    end
  end

  logic [UW-1:0] upper;
  assign upper     = base_q[AW-1:2];
  assign beat_addr = {upper, beat_lsb(base_q[1:0], cnt_q, ilv_q)};

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(beat_addr)); // R9
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> beat_addr[AW-1:2] == $past(beat_addr[AW-1:2])); // R6
  AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> beat_addr[1:0] == base_q[1:0]); // R7
  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load) |=> beat_addr == $past(start_addr)); // R2

endmodule

// File: rtl/lwft_cmd_ctl.sv
module lwft_cmd_ctl
  import lwft_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic          cs_ok,
  input  logic          rd_wr_n,
  input  logic [NB-1:0] bwe_n,
  output op_e           op,
  output logic [NB-1:0] bwe_q
);

  op_e op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_DESEL;
      bwe_q <= '1;
    end else if (en) begin
      bwe_q <= bwe_n;
      if (load) begin
        if (!cs_ok)       op_q <= OP_DESEL;
        else if (rd_wr_n) op_q <= OP_READ;
        else              op_q <= OP_WRITE;
      end
    end
  end

  assign op = op_q;

  AST_DESEL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && op_q == OP_DESEL) |=> op_q == OP_DESEL); // R10
  AST_OP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(op_q) && $stable(bwe_q)); // R9
  AST_ADV_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> op_q == $past(op_q)); // R6

endmodule

// File: rtl/lwft_mem_array.sv
module lwft_mem_array #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic [NB-1:0]   lane_we,
  input  logic [AW-1:0]   waddr,
  input  logic [8*NB-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [8*NB-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[g]) store[waddr] <= wdata[8*g +: 8];
    end
    assign rdata[8*g +: 8] = store[raddr];
  end

endmodule

// File: rtl/lwft_sram.sv
module lwft_sram
  import lwft_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cen_n,
  input  logic            cs0_n,
  input  logic            cs1,
  input  logic            cs2_n,
  input  logic            adv,
  input  logic            rd_wr_n,
  input  logic [NB-1:0]   bwe_n,
  input  logic [AW-1:0]   addr,
  input  logic            ilv,
  input  logic [8*NB-1:0] wdata,
  input  logic            out_en,
  output logic [8*NB-1:0] rdata,
  output logic            rvalid
);

  localparam int DW = 8 * NB;

  logic          en;
  logic          load;
  logic          cs_ok;
  op_e           op;
  logic [NB-1:0] bwe_q;
  logic [AW-1:0] beat_addr;
  logic          commit_evt;
  logic [NB-1:0] lane_we;
  logic [DW-1:0] array_q;

  assign en    = !cen_n;
  assign load  = !adv;
  assign cs_ok = chips_on(cs0_n, cs1, cs2_n);

  lwft_burst_addr #(.AW(AW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .load       (load),
    .start_addr (addr),
    .ilv_in     (ilv),
    .beat_addr  (beat_addr)
  );

  lwft_cmd_ctl #(.NB(NB)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .load    (load),
    .cs_ok   (cs_ok),
    .rd_wr_n (rd_wr_n),
    .bwe_n   (bwe_n),
    .op      (op),
    .bwe_q   (bwe_q)
  );

  // The registered write beat takes its data on the next enabled edge,
  // before the combinational read path sees the array.
  assign commit_evt = en && rst_n && (op == OP_WRITE);
  assign lane_we    = commit_evt ? ~bwe_q : '0;

  lwft_mem_array #(.AW(AW), .NB(NB)) u_mem (
    .clk     (clk),
    .lane_we (lane_we),
    .waddr   (beat_addr),
    .wdata   (wdata),
    .raddr   (beat_addr),
    .rdata   (array_q)
  );

  assign rvalid = (op == OP_READ) && out_en;
  assign rdata  = rvalid ? array_q : '0;

  AST_WRITE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) |-> !rvalid); // R12
  AST_DESEL_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DESEL) |-> !rvalid && lane_we == '0); // R10
  AST_STALL_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cen_n && rvalid) |=> (rvalid || !out_en)); // R9
  AST_NO_WRITE_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |-> lane_we == '0); // R9
  AST_QUIET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0); // R11

endmodule

// File: tb/lwft_sram_tb.sv
module lwft_sram_tb;

  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 8 * NB;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cen_n = 1'b0;
  logic          cs0_n = 1'b0, cs1 = 1'b1, cs2_n = 1'b0;
  logic          adv = 1'b0, rd_wr_n = 1'b1, ilv = 1'b0, out_en = 1'b1;
  logic [NB-1:0] bwe_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  lwft_sram #(.AW(AW), .NB(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .cs0_n(cs0_n), .cs1(cs1),
    .cs2_n(cs2_n), .adv(adv), .rd_wr_n(rd_wr_n), .bwe_n(bwe_n), .addr(addr),
    .ilv(ilv), .wdata(wdata), .out_en(out_en), .rdata(rdata), .rvalid(rvalid)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // Bench model: 0 = deselected, 1 = read, 2 = write
  int            m_op = 0;
  logic [AW-1:0] m_base = '0;
  int            m_cnt = 0;
  logic          m_ilv = 1'b0;
  logic [NB-1:0] m_bwe = '1;
  logic [DW-1:0] m_mem [DEPTH];

  function automatic logic [AW-1:0] m_addr();
    int lo;
    if (m_ilv) lo = int'(m_base[1:0]) ^ m_cnt;
    else       lo = (int'(m_base[1:0]) + m_cnt) % 4;
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  function automatic logic [DW-1:0] pat(input int i);
    return 32'h5A00_0000 ^ (32'(i) * 32'h0101_0103);
  endfunction

  task automatic check(input string tag, input logic [DW:0] got, input logic [DW:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got valid/data %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic cen, input logic sel_ok, input logic a_v,
                       input logic rw, input logic [NB-1:0] be, input logic [AW-1:0] ad,
                       input logic il, input logic [DW-1:0] wd, input logic oe);
    cen_n = cen; cs0_n = 1'b0; cs1 = sel_ok; cs2_n = 1'b0;
    adv = a_v; rd_wr_n = rw; bwe_n = be; addr = ad; ilv = il; wdata = wd; out_en = oe;
  endtask

  task automatic step(input string tag);
    logic          exp_v;
    logic [DW-1:0] exp_d;
    logic [AW-1:0] wa;
    logic          sel;
    @(posedge clk);
    if (!rst_n) begin
      m_op = 0;
      m_bwe = '1;
    end else if (!cen_n) begin
      if (m_op == 2) begin
        wa = m_addr();
        for (int i = 0; i < NB; i++)
          if (!m_bwe[i]) m_mem[wa][8*i +: 8] = wdata[8*i +: 8];
      end
      m_bwe = bwe_n;
      if (!adv) begin
        sel = (cs0_n == 1'b0) && (cs1 == 1'b1) && (cs2_n == 1'b0);
        m_op = !sel ? 0 : (rd_wr_n ? 1 : 2);
        m_base = addr; m_cnt = 0; m_ilv = ilv;
      end else begin
        m_cnt = (m_cnt + 1) % 4;
      end
    end
    @(negedge clk);
    exp_v = (m_op == 1) && out_en;
    exp_d = exp_v ? m_mem[m_addr()] : '0;
    check(tag, {rvalid, rdata}, {exp_v, exp_d});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    void'($urandom(32'd7331));

    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset", {rvalid, rdata}, '0);
    rst_n = 1'b1;

    // R4 / R12: streaming fill, data one beat behind its command
    for (int i = 0; i < DEPTH; i++) begin
      drive(0, 1, 0, 0, '0, AW'(i), 0, (i == 0) ? '0 : pat(i - 1), 1);
      step("R12 write beat no output");
    end
    drive(0, 1, 0, 1, '1, AW'(0), 0, pat(DEPTH - 1), 1);
    step("R4 fill last");
    for (int i = 0; i < DEPTH; i++) m_mem[i] = pat(i);

    // R3: flow-through reads
    for (int i = 8; i < 12; i++) begin
      drive(0, 1, 0, 1, '1, AW'(i), 0, '0, 1);
      step("R3 read");
    end

    // R4: write then read the same word back to back
    drive(0, 1, 0, 0, '0, AW'(9), 0, '0, 1);
    step("R4 write cmd");
    drive(0, 1, 0, 1, '1, AW'(9), 0, 32'hCAFE_F00D, 1);
    step("R4 read after write");

    // R5: aborted write and partial byte write
    drive(0, 1, 0, 0, '1, AW'(10), 0, '0, 1);
    step("R5 abort cmd");
    drive(0, 1, 0, 1, '1, AW'(10), 0, 32'hDEAD_BEEF, 1);
    step("R5 abort keeps word");
    drive(0, 1, 0, 0, 4'b1010, AW'(11), 0, '0, 1);
    step("R5 partial cmd");
    drive(0, 1, 0, 1, '1, AW'(11), 0, 32'h1122_3344, 1);
    step("R5 partial lanes");

    // R7 and R6: linear read burst from low bits 2, ignored pins toggled
    drive(0, 1, 0, 1, '1, AW'(14), 0, '0, 1);
    step("R7 linear load");
    for (int k = 0; k < 5; k++) begin
      drive(0, 0, 1, 0, '0, AW'(33 + k), 1, '0, 1);
      step("R7 R6 linear beat");
    end

    // R8: interleaved read burst from low bits 1
    drive(0, 1, 0, 1, '1, AW'(13), 1, '0, 1);
    step("R8 interleaved load");
    for (int k = 0; k < 4; k++) begin
      drive(0, 1, 1, 1, '1, AW'(2), 0, '0, 1);
      step("R8 interleaved beat");
    end

    // R6: interleaved write burst with per-beat byte enables, then read back
    drive(0, 1, 0, 0, 4'b0000, AW'(22), 1, '0, 1);
    step("R6 write burst load");
    for (int k = 0; k < 4; k++) begin
      drive(0, 1, 1, 1, (k == 1) ? 4'b1100 : 4'b0000, AW'(0), 0, pat(100 + k), 1);
      step("R6 write burst beat");
    end
    drive(0, 1, 0, 1, '1, AW'(20), 0, pat(104), 1);
    step("R6 read back");
    for (int k = 0; k < 3; k++) begin
      drive(0, 1, 1, 1, '1, AW'(0), 0, '0, 1);
      step("R6 read back beat");
    end

    // R9: stall during a read and during a pending write
    drive(0, 1, 0, 1, '1, AW'(3), 0, '0, 1);
    step("R9 read load");
    for (int k = 0; k < 2; k++) begin
      drive(1, 1, 0, 0, '0, AW'(40), 1, 32'hBAD0_0000, 1);
      step("R9 read held in stall");
    end
    drive(0, 1, 0, 0, '0, AW'(4), 0, '0, 1);
    step("R9 write cmd");
    drive(1, 1, 0, 1, '1, AW'(5), 0, 32'hBAD1_1111, 1);
    step("R9 stalled write");
    drive(0, 1, 0, 1, '1, AW'(4), 0, 32'h0BAD_CAFE, 1);
    step("R9 write after stall");

    // R10: deselect and continued deselect
    drive(0, 0, 0, 1, '0, AW'(6), 0, '0, 1);
    step("R10 deselect");
    for (int k = 0; k < 3; k++) begin
      drive(0, 1, 1, 0, '0, AW'(6), 0, 32'hFFFF_0000, 1);
      step("R10 deselect continue");
    end
    drive(0, 1, 0, 1, '1, AW'(6), 0, '0, 1);
    step("R10 word untouched");

    // R11: output enable off during a read
    drive(0, 1, 1, 1, '1, AW'(6), 0, '0, 0);
    step("R11 out_en low");

    // R1: reset drops a pending write
    drive(0, 1, 0, 0, '0, AW'(20), 0, '0, 1);
    step("R1 write before reset");
    rst_n = 1'b0;
    drive(0, 1, 1, 1, '0, AW'(20), 0, 32'h7777_7777, 1);
    step("R1 in reset");
    rst_n = 1'b1;
    drive(0, 1, 1, 1, '0, AW'(20), 0, 32'h8888_8888, 1);
    step("R1 first edge after reset");
    drive(0, 1, 0, 1, '1, AW'(20), 0, '0, 1);
    step("R1 word kept");

    // R2: constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic c, s, a, w, il, oe;
      logic [NB-1:0] be;
      r = $urandom; c = (r[3:0] == 4'd0);
      r = $urandom; s = (r[2:0] != 3'd0);
      r = $urandom; a = r[0]; w = r[1]; il = r[2]; oe = (r[5:3] != 3'd0);
      r = $urandom; be = (r[1:0] == 2'd0) ? r[NB+1:2] : '0;
      r = $urandom;
      drive(c, s, a, w, be, r[AW-1:0], il, $urandom, oe);
      step("R2 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule